// File: doc/BRIEF.md
# Chained Parity Generator/Checker with Shared Parity Pin

This block computes or checks the parity of a data word made of one or more nine-bit slices. Each slice folds its nine bits into an odd/even flag and passes that flag to the next slice, so the flag out of the last slice covers the whole word. A single parity pin is shared between the two directions. It is modelled as three separate signals: a value in, a value out and an output enable.

A mode input picks the direction. In transmit mode (mode low) the block drives the pin with a bit chosen so that the word plus that bit holds an odd number of ones. The active-low error flag stays inactive in this mode. In receive mode (mode high) the block releases the pin and samples the bit that another agent drives. It pulls the error flag low when the word plus the received bit holds an even number of ones.

A parameter can add one output register stage with a synchronous, active-high reset. Without it the block is purely combinational.

Top module: `parity_io_unit`

## Requirements
- R1: While `rst` is high at a clock edge with the output stage present, the outputs become `err_n`=1, `par_oe`=0 and `par_out`=0.
- R2: In transmit mode (`rx_mode`=0), `par_oe`=1, and `par_out` is 1 when the full word has an even number of ones and 0 when the count is odd.
- R3: In transmit mode, `err_n` is 1 for every data value.
- R4: In receive mode (`rx_mode`=1), `par_oe`=0 and `par_out`=0.
- R5: In receive mode, `err_n` is 0 exactly when the count of ones in `data_in` plus `par_in` is even, and 1 when that count is odd.
- R6: Slices are chained. Slice k XORs its nine bits (`data_in[9k+8:9k]`) with the flag from slice k-1, and only the last slice's flag sets the pin and the error flag. A change in any slice therefore affects the results.
- R7: With `REG_OUT`=1, a change at the inputs reaches the outputs at the first rising clock edge after the change, and not before. With `REG_OUT`=0, it reaches them in the same cycle.
- R8: In transmit mode, `par_in` has no effect on any output.
- R9: Reset is synchronous. Asserting `rst` in the middle of operation clears the outputs at the next edge, and normal results return one edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 9*SLICES | Data word, slice k at bits 9k+8..9k |
| rx_mode | input | 1 | 0 = transmit (drive pin), 1 = receive (check pin) |
| par_in | input | 1 | Parity value seen on the shared pin |
| par_out | output | 1 | Parity value driven onto the pin, valid while par_oe=1 |
| par_oe | output | 1 | Pin drive enable |
| err_n | output | 1 | Active-low parity error flag |

## Verification
With the default output stage, every result (`par_out`, `par_oe`, `err_n`) is due at the first rising edge after the inputs change. The bench applies inputs on a falling edge and compares on the next falling edge, which is exactly one registering edge later. A dedicated latency check also samples just before that edge, to show that the old value is still held there. For the reset checks, `rst` is applied on a falling edge and the outputs are read on the following falling edge.

// File: rtl/parity_io_pkg.sv
package parity_io_pkg;

    localparam int SLICE_W = 9;

    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } mode_e;

    // Result presented at the pin and flag outputs
    typedef struct packed {
        logic oe;     // drive enable of the shared pin
        logic drive;  // value driven when oe is set
        logic ok_n;   // active-low error flag (1 = no error)
    } pin_res_t;

    localparam pin_res_t RES_IDLE = '{oe: 1'b0, drive: 1'b0, ok_n: 1'b1};

    function automatic logic slice_odd(input logic [SLICE_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/pio_slice.sv
module pio_slice
    import parity_io_pkg::*;
(
    input  logic [SLICE_W-1:0] bits,
    input  logic               casc_in,
    output logic               casc_out
);
    // casc_out is 1 when this slice and all earlier ones hold an odd count
    assign casc_out = slice_odd(bits) ^ casc_in;
endmodule

// File: rtl/pio_chain.sv
module pio_chain
    import parity_io_pkg::*;
#(
    parameter int SLICES = 2,
    localparam int W = SLICES * SLICE_W
) (
    input  logic [W-1:0] data,
    output logic         word_odd
);
    logic [SLICES:0] link;
    assign link[0] = 1'b0;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        pio_slice u_slice (
            .bits     (data[k*SLICE_W +: SLICE_W]),
            .casc_in  (link[k]),
            .casc_out (link[k+1])
        );
    end

    assign word_odd = link[SLICES];
endmodule

// File: rtl/pio_port.sv
module pio_port
    import parity_io_pkg::*;
(
    input  mode_e    mode,
    input  logic     word_odd,
    input  logic     pin_val,
    output pin_res_t res
);
    always_comb begin
        res = RES_IDLE;
        if (mode == MODE_TX) begin
            res.oe    = 1'b1;
            res.drive = ~word_odd;   // make word plus bit odd
            res.ok_n  = 1'b1;
        end else begin
            res.oe    = 1'b0;
            res.drive = 1'b0;
            res.ok_n  = word_odd ^ pin_val; // odd total is good
        end
    end
endmodule

// File: rtl/pio_stage.sv
module pio_stage
    import parity_io_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_res_t d,
    output pin_res_t q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= RES_IDLE;
            else     q <= d;
        end
    end else begin : g_wire
        logic unused_clkrst;
        assign unused_clkrst = clk ^ rst;
        assign q = d;
    end
endmodule

// File: rtl/parity_io_unit.sv
module parity_io_unit
    import parity_io_pkg::*;
#(
    parameter int SLICES  = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int W = SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] data_in,
    input  logic         rx_mode,
    input  logic         par_in,
    output logic         par_out,
    output logic         par_oe,
    output logic         err_n
);
    logic     word_odd;
    pin_res_t res_now;
    pin_res_t res_out;

    pio_chain #(.SLICES(SLICES)) u_chain (
        .data     (data_in),
        .word_odd (word_odd)
    );

    pio_port u_port (
        .mode     (mode_e'(rx_mode)),
        .word_odd (word_odd),
        .pin_val  (par_in),
        .res      (res_now)
    );

    pio_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (res_now),
        .q   (res_out)
    );

    assign par_out = res_out.drive;
    assign par_oe  = res_out.oe;
    assign err_n   = res_out.ok_n;
endmodule

// File: rtl/parity_io_checker.sv
module parity_io_checker #(
    parameter int W       = 18,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] data_in,
    input logic         rx_mode,
    input logic         par_in,
    input logic         par_out,
    input logic         par_oe,
    input logic         err_n
);
    // R3: flag inactive whenever the pin is driven
    assert_tx_flag_high_R3: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> err_n);

    // R4: released pin carries no value
    assert_rx_released_R4: assert property (@(posedge clk) disable iff (rst)
        !par_oe |-> !par_out);

    if (REG_OUT) begin : g_reg
        // R1, R9: reset clears the outputs at the next edge
        assert_reset_clears_R1: assert property (@(posedge clk)
            rst |=> (err_n && !par_oe && !par_out));

        // R2: one edge after a transmit request the pin is driven with the parity
        assert_tx_drive_R2: assert property (@(posedge clk) disable iff (rst)
            !rx_mode |=> (par_oe && (par_out == ($countones($past(data_in)) % 2 == 0))));

        // R5: one edge after a receive request the flag reflects the total count
        assert_rx_check_R5: assert property (@(posedge clk) disable iff (rst)
            rx_mode |=> (!par_oe &&
                (err_n == (($countones($past(data_in)) + int'($past(par_in))) % 2 == 1))));
    end else begin : g_comb
        assert_tx_drive_R2: assert property (@(posedge clk) disable iff (rst)
            !rx_mode |-> (par_oe && (par_out == ($countones(data_in) % 2 == 0))));

        assert_rx_check_R5: assert property (@(posedge clk) disable iff (rst)
            rx_mode |-> (!par_oe &&
                (err_n == (($countones(data_in) + int'(par_in)) % 2 == 1))));
    end
endmodule

bind parity_io_unit parity_io_checker #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/parity_io_unit_test.sv
`timescale 1ns/1ps
module parity_io_unit_test;
    localparam int SLICES = 2;
    localparam int W      = SLICES * 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         rx_mode = 1'b0;
    logic         par_in = 1'b0;
    logic         par_out, par_oe, err_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    parity_io_unit #(.SLICES(SLICES), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .data_in(data_in), .rx_mode(rx_mode),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive on a falling edge; results due after one rising edge
    task automatic apply(input logic [W-1:0] d, input logic m, input logic p);
        @(negedge clk);
        data_in = d; rx_mode = m; par_in = p;
        @(negedge clk);
    endtask

    function automatic logic ref_drive(input logic [W-1:0] d);
        return ($countones(d) % 2) == 0;
    endfunction

    function automatic logic ref_ok(input logic [W-1:0] d, input logic p);
        return (($countones(d) + int'(p)) % 2) == 1;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "err_n in reset", err_n, 1'b1);
        check("R1", "par_oe in reset", par_oe, 1'b0);
        check("R1", "par_out in reset", par_out, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_tx_sweep();
        for (int v = 0; v < 512; v++) begin
            logic [W-1:0] d;
            d = W'(v);
            apply(d, 1'b0, v[0]);
            check("R2", "tx par_oe", par_oe, 1'b1);
            check("R2", "tx par_out", par_out, ref_drive(d));
            check("R3", "tx err_n", err_n, 1'b1);
        end
    endtask

    task automatic t_rx_sweep();
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 512; v++) begin
                logic [W-1:0] d;
                d = W'(v);
                apply(d, 1'b1, p[0]);
                check("R4", "rx par_oe", par_oe, 1'b0);
                check("R4", "rx par_out", par_out, 1'b0);
                check("R5", "rx err_n", err_n, ref_ok(d, p[0]));
            end
        end
    endtask

    task automatic t_chain();
        for (int v = 0; v < 512; v++) begin
            logic [W-1:0] d;
            d = {9'(v), 9'h0A5};
            apply(d, 1'b0, 1'b0);
            check("R6", "chain tx par_out", par_out, ref_drive(d));
            apply(d, 1'b1, v[3]);
            check("R6", "chain rx err_n", err_n, ref_ok(d, v[3]));
        end
    endtask

    task automatic t_latency();
        apply('0, 1'b0, 1'b0);
        check("R7", "settled par_out", par_out, 1'b1);
        @(negedge clk);
        data_in = W'(1);
        #2;
        check("R7", "par_out held before edge", par_out, 1'b1);
        @(negedge clk);
        check("R7", "par_out after one edge", par_out, 1'b0);
        rx_mode = 1'b1; par_in = 1'b0;
        #2;
        check("R7", "par_oe held before edge", par_oe, 1'b1);
        @(negedge clk);
        check("R7", "par_oe after one edge", par_oe, 1'b0);
    endtask

    task automatic t_pin_ignored();
        logic [W-1:0] d;
        d = 18'h2_3C41;
        apply(d, 1'b0, 1'b0);
        check("R8", "par_out pin low", par_out, ref_drive(d));
        check("R8", "err_n pin low", err_n, 1'b1);
        apply(d, 1'b0, 1'b1);
        check("R8", "par_out pin high", par_out, ref_drive(d));
        check("R8", "err_n pin high", err_n, 1'b1);
        check("R8", "par_oe pin high", par_oe, 1'b1);
    endtask

    task automatic t_sync_reset();
        logic [W-1:0] d;
        d = 18'h0_0003;             // even count, driven bit 1
        apply(d, 1'b0, 1'b0);
        check("R9", "before reset par_oe", par_oe, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        #2;
        check("R9", "reset not yet sampled", par_oe, 1'b1);
        @(negedge clk);
        check("R9", "par_oe cleared", par_oe, 1'b0);
        check("R9", "par_out cleared", par_out, 1'b0);
        check("R9", "err_n released", err_n, 1'b1);
        rx_mode = 1'b1; par_in = 1'b0;   // even total -> error once out of reset
        @(negedge clk);
        check("R9", "err_n held in reset", err_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "err_n after release", err_n, 1'b0);
    endtask

    initial begin
        t_reset();
        t_tx_sweep();
        t_rx_sweep();
        t_chain();
        t_latency();
        t_pin_ignored();
        t_sync_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule